// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the embedded controller of a byte-wide parallel NOR flash. It watches bus write cycles (address, data, active-low write strobe) and recognises two-step unlock sequences that start a byte program or a sector erase. The storage behind it is a small register file split into equal sectors. Once an operation has been accepted, the device stops returning array data and instead reports progress on the data lines. It leaves its operating mode only when it receives a reset command.

Sector erases are collected into a batch. Each further sector-address write that arrives inside a quiet window adds its sector and restarts the window. The whole batch runs only after the window passes with no new request. Byte programs can be chained without repeating the unlock. Any failure freezes the device in a status-reporting state until a reset. A failure is an attempt to turn a 0 bit back into 1, or an erase that touches a protected sector.

All timing is counted in clock cycles. The quiet window, the erase time and the program time are parameters, so a simulation can use short values.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the device is in read mode and `ready` is 1. Every array byte reads 0xFF.
- R2: A write happens on each clock edge where `we_n` is 0. While `oe_n` is 0 in read mode, `dout` shows the byte at `addr[MEM_AW-1:0]`. While `oe_n` is 1, `dout` is 0x00. Writes in read mode that do not start an unlock have no effect on the array.
- R3: The program sequence is 0xAA to 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, and then one write carrying the address and the data. The device then stays busy for exactly PROG_CYC cycles. After that the byte holds old AND data.
- R4: After a successful program the device stays in program mode. A single write, of any data except 0xF0, starts a new program at its address with no unlock. Reads in this mode return array data.
- R5: The erase sequence is 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, and then 0x30 written to an address in the sector. The sector is the top SEC_AW bits of `addr[MEM_AW-1:0]`. Each further 0x30 write during the window adds its sector and restarts the WIN_CYC-cycle window. The erase starts WIN_CYC cycles after the last such write. It lasts ERASE_CYC cycles, and every batched sector then reads 0xFF.
- R6: In the window, busy and failure states, a read returns a status word instead of array data. Bit 7 is the inverse of bit 7 of the program data, and 0 for an erase. Bit 6 flips on every status read. Bit 5 is the error flag. Bit 3 is 1 once the erase window has closed. All other bits are 0.
- R7: `ready` is 0 during the erase window, during any running operation, and in the failure state. It is 1 otherwise.
- R8: If the program data has a 1 where the stored byte has a 0, the byte still becomes old AND data. The error bit is then set, and the device stays in the status state, returning status for every read, until a reset.
- R9: An erase batch that contains a sector whose PROT_MASK bit is set leaves that sector unchanged. It still erases the other sectors in the batch and then enters the failure state with the error bit set.
- R10: A 0xF0 write to any address returns the device to read mode and clears the error bit. This applies in read mode, partway through a command prefix, in program or erase mode, and in the failure state.
- R11: A write that does not match the next expected step of an unlock or command prefix aborts to read mode. Writes during a running program or erase are ignored.
- R12: After a successful erase the device stays in erase mode. A 0x30 write to a sector address opens a new window without an unlock. Reads in this mode return array data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Bus address for reads and writes |
| din | input | 8 | Write data |
| we_n | input | 1 | Active-low write strobe; one write per clock while low |
| oe_n | input | 1 | Active-low output enable; one read per clock while low |
| dout | output | 8 | Array byte or status word |
| ready | output | 1 | High when no operation, window or failure is pending |

## Verification
The bench builds the block with a 64-byte array in four 16-byte sectors and the top sector protected. It uses an 8-cycle quiet window, a 20-cycle erase time and a 5-cycle program time. These short values let it measure the window and the busy times cycle by cycle. They also let it restart the window mid-way with a second sector, and they make room for a few dozen randomly chosen programs, both passing and failing, checked against a byte model.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W    = 11,
  parameter int MEM_AW    = 6,
  parameter int SEC_AW    = 2,
  parameter int WIN_CYC   = 2500,
  parameter int ERASE_CYC = 50000,
  parameter int PROG_CYC  = 500,
  parameter logic [(1<<SEC_AW)-1:0] PROT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              we_n,
  input  logic              oe_n,
  output logic [7:0]        dout,
  output logic              ready
);
  localparam int NSEC  = 1 << SEC_AW;
  localparam int DEPTH = 1 << MEM_AW;
  localparam int SSA   = MEM_AW - SEC_AW;
  localparam int MAXC  = (WIN_CYC > ERASE_CYC) ? ((WIN_CYC > PROG_CYC) ? WIN_CYC : PROG_CYC)
                                               : ((ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC);
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(12'h2AA);

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PADDR, S_E1, S_E2, S_E3,
    S_WIN, S_EBUSY, S_PBUSY, S_PMODE, S_EMODE, S_FAIL
  } st_t;

  st_t               st;
  logic [7:0]        mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic [NSEC-1:0]   pend;
  logic [MEM_AW-1:0] pa;
  logic [7:0]        pd;
  logic              inv7, tog, err, was_erase;

  wire               wr     = !we_n;
  wire [MEM_AW-1:0]  wa     = addr[MEM_AW-1:0];
  wire [SEC_AW-1:0]  sec    = addr[MEM_AW-1:SSA];
  wire               hit_hi = (addr == A_HI);
  wire               hit_lo = (addr == A_LO);
  wire               rst_cmd = wr && (din == 8'hF0);
  wire               stat_mode = (st == S_WIN) || (st == S_EBUSY) || (st == S_PBUSY) || (st == S_FAIL);
  wire               closed = (st == S_EBUSY) || (st == S_FAIL && was_erase);
  wire [7:0]         status = {inv7, tog, err, 1'b0, closed, 3'b000};
  wire               prog_bad  = |(pd & ~mem[pa]);
  wire               erase_bad = |(pend & PROT_MASK);

  assign dout  = oe_n ? 8'h00 : (stat_mode ? status : mem[wa]);
  assign ready = !stat_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_READ;
      cnt <= '0;
      pend <= '0;
      pa <= '0;
      pd <= '0;
      inv7 <= 1'b0;
      tog <= 1'b0;
      err <= 1'b0;
      was_erase <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (!oe_n && stat_mode) tog <= !tog;
      case (st)
        S_READ:
          if (wr && hit_hi && din == 8'hAA) st <= S_U1;
        S_U1:
          if (wr) st <= (hit_lo && din == 8'h55) ? S_U2 : S_READ;
        S_U2:
          if (wr) begin
            if (hit_hi && din == 8'hA0)      st <= S_PADDR;
            else if (hit_hi && din == 8'h80) st <= S_E1;
            else                             st <= S_READ;
          end
        S_E1:
          if (wr) st <= (hit_hi && din == 8'hAA) ? S_E2 : S_READ;
        S_E2:
          if (wr) st <= (hit_lo && din == 8'h55) ? S_E3 : S_READ;
        S_E3, S_EMODE:
          if (rst_cmd) st <= S_READ;
          else if (wr && din == 8'h30) begin
            pend <= '0;
            pend[sec] <= 1'b1;
            cnt <= CW'(WIN_CYC - 1);
            inv7 <= 1'b0;
            was_erase <= 1'b1;
            st <= S_WIN;
          end else if (wr && st == S_E3) st <= S_READ;
        S_PADDR, S_PMODE:
          if (st == S_PMODE && rst_cmd) st <= S_READ;
          else if (wr) begin
            pa <= wa;
            pd <= din;
            inv7 <= !din[7];
            was_erase <= 1'b0;
            cnt <= CW'(PROG_CYC - 1);
            st <= S_PBUSY;
          end
        S_WIN:
          if (wr && din == 8'h30) begin
            pend[sec] <= 1'b1;
            cnt <= CW'(WIN_CYC - 1);
          end else if (cnt == '0) begin
            cnt <= CW'(ERASE_CYC - 1);
            st <= S_EBUSY;
          end else cnt <= cnt - 1'b1;
        S_EBUSY:
          if (cnt == '0) begin
            for (int i = 0; i < DEPTH; i++)
              if (pend[i[MEM_AW-1:SSA]] && !PROT_MASK[i[MEM_AW-1:SSA]]) mem[i[MEM_AW-1:0]] <= 8'hFF;
            pend <= '0;
            err <= erase_bad;
            st <= erase_bad ? S_FAIL : S_EMODE;
          end else cnt <= cnt - 1'b1;
        S_PBUSY:
          if (cnt == '0) begin
            mem[pa] <= mem[pa] & pd;
            err <= prog_bad;
            st <= prog_bad ? S_FAIL : S_PMODE;
          end else cnt <= cnt - 1'b1;
        S_FAIL:
          if (rst_cmd) begin
            err <= 1'b0;
            st <= S_READ;
          end
        default: st <= S_READ;
      endcase
      if (rst_cmd && (st == S_READ || st == S_U1 || st == S_U2 || st == S_E1 || st == S_E2)) st <= S_READ;
    end
  end

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAIL && !rst_cmd) |=> (st == S_FAIL && !ready));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && stat_mode && $past(!oe_n && stat_mode)) |-> (dout[6] != $past(dout[6])));

  // R5
  win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN && wr && din == 8'h30) |=> (st == S_WIN && cnt == CW'(WIN_CYC - 1)));

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PBUSY && cnt != '0) |=> !ready);

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_U1 && wr && !(hit_lo && din == 8'h55)) |=> (st == S_READ));

  // R9
  prot_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EBUSY && cnt == '0 && erase_bad) |=> (st == S_FAIL && dout[5] == !oe_n));
endmodule

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
  localparam int AW = 11, MA = 6, SA = 2, W = 8, E = 20, P = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic we_n = 1'b1, oe_n = 1'b1;
  wire [7:0] dout;
  wire ready;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] model [64];

  always #10 clk = ~clk;

  flash_cmd_fsm #(.ADDR_W(AW), .MEM_AW(MA), .SEC_AW(SA), .WIN_CYC(W), .ERASE_CYC(E),
                  .PROG_CYC(P), .PROT_MASK(4'b1000)) u_flash_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .we_n(we_n), .oe_n(oe_n),
    .dout(dout), .ready(ready));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    addr = a; oe_n = 1'b0; #1 d = dout;
    @(negedge clk); oe_n = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic prog_cmd(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_cmd(input int s);
    unlock(); wr(11'h555, 8'h80); unlock(); wr(AW'(s << (MA - SA)), 8'h30);
  endtask

  task automatic reset_cmd();
    wr(11'h000, 8'hF0);
  endtask

  function automatic logic [7:0] stat_exp(input logic b7, input logic er, input logic cl);
    return {b7, 1'b0, er, 1'b0, cl, 3'b000};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    int n, j;
    void'($urandom(32'd2022));
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", {7'd0, ready}, 8'h01);
    rd(11'h005, v); chk("R1 array", v, 8'hFF);
    // R2 output idle when oe_n high
    #1 chk("R2 oe_n high", dout, 8'h00);

    // R3 program with status and busy time
    prog_cmd(11'h012, 8'h5A);
    rd(11'h012, v); rd(11'h012, v2);
    chk("R6 status prog", v & 8'hBF, stat_exp(1'b1, 1'b0, 1'b0));
    chk("R6 toggle", {7'd0, v[6] ^ v2[6]}, 8'h01);
    chk("R7 ready busy", {7'd0, ready}, 8'h00);
    wait_ready(n);
    chk("R3 program time", 8'(n + 2), 8'(P));
    rd(11'h012, v); chk("R3 programmed", v, 8'h5A); model[8'h12] = 8'h5A;

    // R4 chained program, R11 write ignored during busy
    wr(11'h013, 8'h0F);
    wr(11'h02F, 8'h00);
    wait_ready(n);
    rd(11'h013, v); chk("R4 chained", v, 8'h0F); model[8'h13] = 8'h0F;
    rd(11'h02F, v); chk("R11 busy write ignored", v, 8'hFF);

    // R10 reset then a plain write does nothing (R2)
    reset_cmd();
    wr(11'h014, 8'h00);
    rd(11'h014, v); chk("R2 plain write ignored", v, 8'hFF);

    // R8 failing program
    prog_cmd(11'h012, 8'hA5);
    repeat (P + 2) @(negedge clk);
    chk("R8 ready stuck", {7'd0, ready}, 8'h00);
    rd(11'h012, v); chk("R8 status on read", v & 8'hBF, stat_exp(1'b0, 1'b1, 1'b0));
    reset_cmd();
    rd(11'h012, v); chk("R10 reset after fail", v, 8'h00); model[8'h12] = 8'h00;
    chk("R10 ready", {7'd0, ready}, 8'h01);

    // R11 aborted prefix
    wr(11'h555, 8'hAA); wr(11'h123, 8'h55);
    wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h020, 8'h00);
    rd(11'h020, v); chk("R11 abort", v, 8'hFF);

    // R10 reset inside a prefix
    unlock(); reset_cmd(); wr(11'h555, 8'hA0); wr(11'h021, 8'h00);
    rd(11'h021, v); chk("R10 prefix reset", v, 8'hFF);

    // set up sectors 0 and 2
    prog_cmd(11'h003, 8'h00); wait_ready(n); reset_cmd(); model[3] = 8'h00;
    prog_cmd(11'h025, 8'h11); wait_ready(n); reset_cmd(); model[8'h25] = 8'h11;

    // R5 batch with restart
    erase_cmd(0);
    chk("R7 ready in window", {7'd0, ready}, 8'h00);
    rd(11'h000, v); chk("R6 window status", v & 8'hBF, stat_exp(1'b0, 1'b0, 1'b0));
    repeat (4) @(negedge clk);
    wr(11'h010, 8'h30);
    j = 0;
    forever begin
      rd(11'h000, v);
      if (v[3] || j > 100) break;
      j++;
    end
    chk("R5 window length", 8'(j), 8'(W));
    chk("R6 closed status", v & 8'hBF, stat_exp(1'b0, 1'b0, 1'b1));
    wait_ready(n);
    chk("R5 erase time", 8'(n), 8'(E - 1));
    rd(11'h003, v); chk("R5 sector0 erased", v, 8'hFF);
    rd(11'h012, v); chk("R5 sector1 erased", v, 8'hFF);
    rd(11'h013, v); chk("R5 sector1 erased b", v, 8'hFF);
    rd(11'h025, v); chk("R12 sector2 untouched", v, 8'h11);
    for (int i = 0; i < 32; i++) model[i] = 8'hFF;

    // R12 erase mode keeps accepting sectors
    wr(11'h020, 8'h30);
    chk("R12 window reopened", {7'd0, ready}, 8'h00);
    wait_ready(n);
    rd(11'h025, v); chk("R12 sector2 erased", v, 8'hFF); model[8'h25] = 8'hFF;
    reset_cmd();

    // R9 protected sector in batch
    prog_cmd(11'h031, 8'h00); wait_ready(n); reset_cmd(); model[8'h31] = 8'h00;
    prog_cmd(11'h022, 8'h00); wait_ready(n); reset_cmd();
    erase_cmd(3); wr(11'h020, 8'h30);
    repeat (W + E + 4) @(negedge clk);
    chk("R9 ready stuck", {7'd0, ready}, 8'h00);
    rd(11'h031, v); chk("R9 fail status", v & 8'hBF, stat_exp(1'b0, 1'b1, 1'b1));
    reset_cmd();
    rd(11'h031, v); chk("R9 protected kept", v, 8'h00);
    rd(11'h022, v); chk("R9 other erased", v, 8'hFF); model[8'h22] = 8'hFF;

    // random programs, R3 and R8 against model
    for (int k = 0; k < 40; k++) begin
      logic [5:0] a;
      logic [31:0] r;
      logic [7:0] d;
      logic bad;
      a = 6'($urandom % 48);
      r = $urandom;
      d = r[8] ? (model[a] & r[7:0]) : r[7:0];
      bad = |(d & ~model[a]);
      prog_cmd(AW'(a), d);
      repeat (P + 1) @(negedge clk);
      chk(bad ? "R8 random ready" : "R3 random ready", {7'd0, ready}, {7'd0, !bad});
      if (bad) begin
        rd(AW'(a), v); chk("R8 random err", {7'd0, v[5]}, 8'h01);
      end
      reset_cmd();
      model[a] = model[a] & d;
      rd(AW'(a), v); chk("R3 random data", v, model[a]);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule